// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel. It advances once for every cycle in which the counter clock enable is high. It produces a channel output whose waveform depends on the selected operating mode, and it exposes the current count. A separate host-side block supplies a 3-bit mode code and a reload value. That block pulses a load strobe to commit both.

The channel keeps its position as a number of elapsed ticks since the last restart. A restart is caused by a load, or by a rising gate edge in the modes that retrigger. The visible count and the output are derived from the elapsed ticks and the reload value. The modes cover the following:

- a terminal-count level change
- a gate-triggered one-shot
- a periodic rate pulse
- a square wave whose high half is rounded up for odd reload values
- software-triggered and gate-triggered single-tick strobes

A reload value of zero stands for 65536.

Top module: `pit_channel`

## Requirements
- R1: While reset is asserted and after its release, the channel is in mode 0 with an effective reload of 65536 and zero elapsed ticks, so the count reads 0x0000 and the output is low.
- R2: A load strobe captures the mode code and the reload value and sets elapsed ticks to zero. It takes precedence over a tick or a gate edge in the same cycle. In the next cycle the count reads the reload value in every mode.
- R3: In modes 0, 1, 4 and 5, the count equals the reload value minus elapsed ticks, taken modulo 65536.
- R4: In modes 0 and 1, the output is low while elapsed ticks are below the reload value and high once they reach it. In mode 0 it then stays high until the next load.
- R5: In mode 2, the count equals the reload value minus (elapsed modulo reload). The output is high for exactly the states where elapsed modulo reload is zero and elapsed is non-zero, and low otherwise.
- R6: In mode 3, the count equals the reload value minus ((2 × elapsed) modulo reload). The output is high while elapsed modulo reload is below (reload + 1) / 2, rounded down, and low otherwise.
- R7: In modes 4 and 5, the output is high only in the state where elapsed ticks equal the reload value. In that state the count reads 0x0000.
- R8: A rising gate edge (gate high in a cycle after a cycle with gate low) sets elapsed ticks to zero in modes 1, 2, 3 and 5. In modes 0 and 4 it does not restart counting.
- R9: In modes 0, 2, 3 and 4, a low gate holds elapsed ticks. In modes 1 and 5, the gate level does not affect counting.
- R10: A reload value of 0x0000 acts as 65536. In mode 0 the count reads 0xFFFF after one tick, and the output rises only after 65536 ticks.
- R11: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R12: In a cycle with the tick enable low, no load and a low gate, the count and the output do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter clock enable; one tick per high cycle |
| gate | input | 1 | Gate level; its rising edge retriggers and its low level suspends, per mode |
| mode_sel | input | 3 | Mode code, captured on load |
| reload | input | 16 | Reload value, captured on load; 0 means 65536 |
| load | input | 1 | Load strobe; commits mode and reload and restarts counting |
| out | output | 1 | Channel output |
| count | output | 16 | Current visible count |

## Verification
The bench targets the following corner cases:

- Odd and even square-wave periods. A design that rounds the high half down would drop the output one tick early on an odd reload.
- The first state after a restart in mode 2. A design that treats elapsed zero as a period boundary would emit a spurious pulse right after every load.
- Gate edges in each mode class. A wrong mode table would either restart a software-triggered mode or ignore a retrigger in a one-shot.
- A full 65536-tick run with reload zero. A design that takes zero literally would finish at once or wrap the count the wrong way.
- A load that coincides with a tick and a gate edge. A wrong priority would leave the count one below the reload value.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic [2:0] {
      MD_TERM     = 3'd0,
      MD_ONESHOT  = 3'd1,
      MD_RATE     = 3'd2,
      MD_SQUARE   = 3'd3,
      MD_SWSTROBE = 3'd4,
      MD_HWSTROBE = 3'd5
   } md_e;

   // Codes 6 and 7 fold onto the rate and square modes.
   function automatic md_e fold_mode(input logic [2:0] code);
      md_e r;
      case (code)
         3'd6:    r = MD_RATE;
         3'd7:    r = MD_SQUARE;
         default: r = md_e'(code);
      endcase
      return r;
   endfunction

   function automatic logic gate_restarts(input md_e m);
      return (m == MD_ONESHOT) || (m == MD_RATE) ||
             (m == MD_SQUARE)  || (m == MD_HWSTROBE);
   endfunction

   function automatic logic gate_suspends(input md_e m);
      return (m == MD_TERM) || (m == MD_RATE) ||
             (m == MD_SQUARE) || (m == MD_SWSTROBE);
   endfunction

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
   import pit_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          gate,
   input  logic [2:0]    mode_in,
   input  logic [CW-1:0] reload_in,
   input  logic          load,
   output md_e           mode_q,
   output logic [CW:0]   n_q,
   output logic [CW:0]   n_next,
   output logic          restart,
   output logic          advance
);
   localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};

   logic gate_q;
   logic gate_rise;

   assign gate_rise = gate & ~gate_q;
   assign n_next    = load ? ((reload_in == '0) ? FULL : {1'b0, reload_in}) : n_q;
   assign restart   = load | (gate_rise & gate_restarts(mode_q));
   assign advance   = ~restart & tick_en & ~(gate_suspends(mode_q) & ~gate);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         mode_q <= MD_TERM;
         n_q    <= FULL;
      end else begin
         gate_q <= gate;
         if (load) begin
            mode_q <= fold_mode(mode_in);
            n_q    <= n_next;
         end
      end
   end
endmodule

// File: rtl/pit_phase.sv
module pit_phase #(
   parameter int CW   = 16,
   parameter int STEP = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        restart,
   input  logic        advance,
   input  logic [CW:0] modulus,
   output logic [CW:0] phase
);
   logic [CW:0] nxt;

   initial begin
      if (STEP < 1 || STEP > 2) $fatal(1, "pit_phase: STEP must be 1 or 2");
   end

   generate
      if (STEP == 1) begin : g_unit
         always_comb begin
            nxt = phase + (CW+1)'(1);
            if (nxt >= modulus) nxt = '0;
         end
      end else begin : g_double
         logic [CW:0] part;
         always_comb begin
            part = phase + (CW+1)'(2);
            if (part >= modulus) part = part - modulus;
            nxt = (part >= modulus) ? (part - modulus) : part;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       phase <= '0;
      else if (restart) phase <= '0;
      else if (advance) phase <= nxt;
   end
endmodule

// File: rtl/pit_term.sv
module pit_term #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          advance,
   input  logic [CW:0]   n_next,
   output logic [CW-1:0] cnt,
   output logic          reached,
   output logic          at_term,
   output logic          started
);
   localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};

   logic [CW:0] rem;
   logic        past;

   assign reached = (rem == '0);
   assign at_term = reached & ~past;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= FULL[CW-1:0];
         rem     <= FULL;
         past    <= 1'b0;
         started <= 1'b0;
      end else if (restart) begin
         cnt     <= n_next[CW-1:0];
         rem     <= n_next;
         past    <= 1'b0;
         started <= 1'b0;
      end else if (advance) begin
         cnt     <= cnt - CW'(1);
         started <= 1'b1;
         if (rem != '0) rem  <= rem - (CW+1)'(1);
         else           past <= 1'b1;
      end
   end
endmodule

// File: rtl/pit_outsel.sv
module pit_outsel
   import pit_pkg::*;
#(
   parameter int CW = 16
) (
   input  md_e           mode,
   input  logic [CW:0]   n,
   input  logic [CW-1:0] cnt,
   input  logic [CW:0]   ph,
   input  logic [CW:0]   ph2,
   input  logic          reached,
   input  logic          at_term,
   input  logic          started,
   output logic          out_o,
   output logic [CW-1:0] count_o
);
   logic [CW:0] half;

   // Rounded-up half period: ceil(n / 2).
   assign half = (n >> 1) + {{CW{1'b0}}, n[0]};

   always_comb begin
      out_o   = 1'b0;
      count_o = cnt;
      case (mode)
         MD_TERM, MD_ONESHOT: begin
            out_o   = reached;
            count_o = cnt;
         end
         MD_RATE: begin
            out_o   = started && (ph == '0);
            count_o = CW'(n - ph);
         end
         MD_SQUARE: begin
            out_o   = (ph < half);
            count_o = CW'(n - ph2);
         end
         default: begin
            out_o   = at_term;
            count_o = cnt;
         end
      endcase
   end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          gate,
   input  logic [2:0]    mode_sel,
   input  logic [CW-1:0] reload,
   input  logic          load,
   output logic          out,
   output logic [CW-1:0] count
);
   initial begin
      if (CW < 2 || CW > 30) $fatal(1, "pit_channel: CW out of range");
   end

   md_e         mode_q;
   logic [CW:0] n_q;
   logic [CW:0] n_next;
   logic        restart;
   logic        advance;
   logic [CW:0] ph;
   logic [CW:0] ph2;
   logic [CW-1:0] cnt;
   logic        reached;
   logic        at_term;
   logic        started;

   pit_ctrl #(.CW(CW)) u_ctrl (
      .clk, .rst_n, .tick_en, .gate,
      .mode_in(mode_sel), .reload_in(reload), .load,
      .mode_q, .n_q, .n_next, .restart, .advance
   );

   // Elapsed modulo period, and twice elapsed modulo period.
   pit_phase #(.CW(CW), .STEP(1)) u_phase1 (
      .clk, .rst_n, .restart, .advance, .modulus(n_q), .phase(ph)
   );
   pit_phase #(.CW(CW), .STEP(2)) u_phase2 (
      .clk, .rst_n, .restart, .advance, .modulus(n_q), .phase(ph2)
   );

   pit_term #(.CW(CW)) u_term (
      .clk, .rst_n, .restart, .advance, .n_next,
      .cnt, .reached, .at_term, .started
   );

   pit_outsel #(.CW(CW)) u_outsel (
      .mode(mode_q), .n(n_q), .cnt, .ph, .ph2,
      .reached, .at_term, .started,
      .out_o(out), .count_o(count)
   );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
   import pit_pkg::*;
#(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_en,
   input logic          gate,
   input logic          load,
   input logic [CW-1:0] reload,
   input logic          out,
   input logic [CW-1:0] count,
   input md_e           mode_q,
   input logic [CW:0]   n_q
);
   // R2
   load_shows_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(reload)));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !load && !gate) |=> ($stable(count) && $stable(out)));

   // R4
   term_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_TERM && out && !load) |=> out);

   // R5
   rate_pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_RATE && out) |-> (count == CW'(n_q)));

   // R7
   strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MD_SWSTROBE || mode_q == MD_HWSTROBE) && out) |-> (count == '0));
endmodule

bind pit_channel pit_channel_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate), .load(load),
   .reload(reload), .out(out), .count(count), .mode_q(mode_q), .n_q(n_q)
);

// File: tb/pit_channel_bench.sv
`timescale 1ns/1ps
module pit_channel_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        gate = 1'b0;
   logic        load = 1'b0;
   logic [2:0]  mode_sel = 3'd0;
   logic [15:0] reload = 16'd0;
   logic        out;
   logic [15:0] count;

   pit_channel #(.CW(16)) u_pit_channel (
      .clk, .rst_n, .tick_en, .gate, .mode_sel, .reload, .load, .out, .count
   );

   always #4 clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   // Reference model state
   int     m_mode = 0;
   longint m_n = 65536;
   longint m_e = 0;
   bit     m_gprev = 1'b0;

   typedef struct {
      logic [15:0] c;
      logic        o;
      string       tag;
   } exp_t;
   exp_t sb[$];

   function automatic int fold(input int md);
      return (md == 6) ? 2 : ((md == 7) ? 3 : md);
   endfunction

   // Driver: apply one cycle of stimulus and push the expected result.
   task automatic step(input bit ld, input logic [15:0] rl, input int md,
                       input bit g, input bit tk, input string tag);
      exp_t   it;
      longint ph;
      @(negedge clk);
      load = ld; reload = rl; mode_sel = 3'(md); gate = g; tick_en = tk;
      if (ld) begin
         m_mode = fold(md);
         m_n    = (rl == 16'd0) ? 65536 : longint'(rl);
         m_e    = 0;
      end else if (g && !m_gprev && (m_mode inside {1, 2, 3, 5})) begin
         m_e = 0;
      end else if (tk && !((m_mode inside {0, 2, 3, 4}) && !g)) begin
         m_e = m_e + 1;
      end
      m_gprev = g;
      case (m_mode)
         2: begin
            ph   = m_e % m_n;
            it.o = (ph == 0) && (m_e != 0);
            it.c = 16'(m_n - ph);
         end
         3: begin
            ph   = m_e % m_n;
            it.o = ph < ((m_n + 1) / 2);
            it.c = 16'(m_n - ((2 * m_e) % m_n));
         end
         4, 5: begin
            it.o = (m_e == m_n);
            it.c = 16'(m_n - m_e);
         end
         default: begin
            it.o = (m_e >= m_n);
            it.c = 16'(m_n - m_e);
         end
      endcase
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic run(input int n, input bit g, input bit tk, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 16'd0, 0, g, tk, tag);
   endtask

   // Monitor: compare after each active edge.
   always @(posedge clk) begin
      exp_t it;
      #2;
      if (sb.size() > 0) begin
         it = sb.pop_front();
         n_checks++;
         if (count !== it.c || out !== it.o) begin
            n_errors++;
            $display("FAIL %s: count=%h out=%b, expected count=%h out=%b",
                     it.tag, count, out, it.c, it.o);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_checks++;
      if (count !== 16'h0000 || out !== 1'b0) begin
         n_errors++;
         $display("FAIL R1 in reset: count=%h out=%b, expected count=0000 out=0", count, out);
      end
      rst_n = 1'b1;

      run(3, 1'b0, 1'b1, "R1 after release, mode 0 gate low (R9)");

      // Mode 0 basic terminal count
      step(1'b1, 16'd5, 0, 1'b1, 1'b1, "R2 load mode 0");
      run(8, 1'b1, 1'b1, "R3 R4 mode 0 count and level");

      // Mode 0 gate suspend; rising edge does not restart
      step(1'b1, 16'd6, 0, 1'b1, 1'b0, "R2 load mode 0 n=6");
      run(2, 1'b1, 1'b1, "R3 mode 0");
      run(3, 1'b0, 1'b1, "R9 mode 0 gate low holds");
      run(5, 1'b1, 1'b1, "R8 mode 0 gate rise resumes only");

      // Mode 1: load with tick and gate edge in the same cycle
      step(1'b0, 16'd0, 0, 1'b0, 1'b0, "R9 setup");
      step(1'b1, 16'd4, 1, 1'b1, 1'b1, "R2 load priority over tick and gate edge");
      run(2, 1'b1, 1'b1, "R4 mode 1");
      run(2, 1'b0, 1'b1, "R9 mode 1 counts with gate low");
      step(1'b0, 16'd0, 0, 1'b1, 1'b1, "R8 mode 1 gate retrigger");
      run(6, 1'b1, 1'b1, "R4 mode 1 after retrigger");

      // Mode 2 rate generator
      step(1'b1, 16'd4, 2, 1'b1, 1'b1, "R2 load mode 2");
      run(10, 1'b1, 1'b1, "R5 mode 2 pulses");
      run(2, 1'b0, 1'b1, "R9 mode 2 gate low holds");
      run(5, 1'b1, 1'b1, "R8 mode 2 gate rise restarts");
      run(3, 1'b0, 1'b0, "R12 tick enable low holds");

      // Mode 3 square wave, odd and even
      step(1'b1, 16'd5, 3, 1'b1, 1'b1, "R2 load mode 3 odd");
      run(12, 1'b1, 1'b1, "R6 mode 3 odd period");
      step(1'b1, 16'd4, 3, 1'b1, 1'b1, "R2 load mode 3 even");
      run(8, 1'b1, 1'b1, "R6 mode 3 even period");

      // Mode 4 software strobe
      step(1'b1, 16'd3, 4, 1'b1, 1'b1, "R2 load mode 4");
      run(6, 1'b1, 1'b1, "R7 mode 4 strobe");
      step(1'b1, 16'd3, 4, 1'b1, 1'b1, "R2 load mode 4 again");
      run(2, 1'b0, 1'b1, "R9 mode 4 gate low holds");
      run(4, 1'b1, 1'b1, "R8 mode 4 gate rise no restart");

      // Mode 5 gate-triggered strobe
      step(1'b1, 16'd3, 5, 1'b0, 1'b1, "R2 load mode 5");
      run(2, 1'b0, 1'b1, "R9 mode 5 counts with gate low");
      step(1'b0, 16'd0, 0, 1'b1, 1'b1, "R8 mode 5 gate trigger");
      run(6, 1'b1, 1'b1, "R7 mode 5 strobe");

      // Aliased codes
      step(1'b1, 16'd3, 6, 1'b1, 1'b1, "R11 code 6 as mode 2");
      run(7, 1'b1, 1'b1, "R11 code 6 behaviour");
      step(1'b1, 16'd3, 7, 1'b1, 1'b1, "R11 code 7 as mode 3");
      run(7, 1'b1, 1'b1, "R11 code 7 behaviour");

      // Reload zero means 65536
      step(1'b1, 16'd0, 0, 1'b1, 1'b1, "R10 load zero");
      run(65540, 1'b1, 1'b1, "R10 full range run");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule